// File: doc/BRIEF.md
# Table-Access Program-Memory Controller

This block holds a small array of 24-bit instruction words and lets a data-side host reach it through table-style operations. Each operation carries an 8-bit page value and a 16-bit effective address, and the two together form a 24-bit target. A low-path operation touches bits 15:0 of the addressed word, and a high-path operation touches bits 23:16. Either path can work on a whole word or on one byte. Table writes never reach the array directly. They fill a bank of row write latches, and a row-program command then folds the latches into one aligned row. Programming can only clear bits.

An erase command restores an aligned block of one, two or four rows to all ones. The 2-bit command operation field chooses between programming and the three erase sizes. A sequencer carries out each command one word per cycle, waits a fixed settle time, and raises `done` on its last busy cycle. The sequencer walks through the states IDLE, WORK, SETTLE and FINISH:
- IDLE to WORK when a command is accepted.
- WORK to SETTLE once the last word of the block has been updated.
- SETTLE to FINISH when the settle counter reaches zero.
- FINISH to IDLE on the next cycle.

Top module: `flash_tbl_ctrl`

## Requirements
- R1: The word index is taken from the offset `{page[6:0], ea[15:1]}`. If page bit 7 is 0, the index selects user space: offset modulo 512. If page bit 7 is 1, it selects configuration space: offset modulo 128. The two spaces are distinct.
- R2: A low word read (high=0, byte=0) returns word bits 15:0. A low word write sets latch bits 15:0 from wdata[15:0].
- R3: A high read with byte=0 returns `{8'h00, word[23:16]}`. A high write with byte=0 sets latch bits 23:16 from wdata[7:0].
- R4: In byte mode, ea[0]=0 selects bits 7:0 and ea[0]=1 selects bits 15:8 of the low path. The byte appears in rd_data[7:0], with rd_data[15:8] reading as zero. A byte write changes only the selected lane, using wdata[7:0].
- R5: A high byte-mode access with ea[0]=1 reads as 16'h0000. A write of that kind is ignored.
- R6: After reset, every word reads 24'hFFFFFF, every latch holds all ones, and busy, done and rd_valid are 0.
- R7: cmd_op=2'b00 programs the 32-word row that contains the target. Each word in the row becomes its old value AND the latch for the same slot. The slot is the offset modulo 32. All latches return to all ones once programming ends.
- R8: cmd_op values 2'b01, 2'b10 and 2'b11 set the words of an aligned block of 32, 64 or 128 words to all ones. The block lies within the target's space.
- R9: When a command is accepted, busy is high for N+7 cycles, where N is the number of words in the block. done is high only in the last of those cycles.
- R10: While busy, table writes and cmd_go have no effect.
- R11: rd_valid is high in exactly the cycle after a cycle with tbl_rd high. rd_data holds the value formatted from the array content at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tbl_page | input | 8 | Page value; bit 7 selects configuration space |
| tbl_ea | input | 16 | Effective address; bit 0 selects the byte |
| tbl_rd | input | 1 | Table read strobe |
| tbl_wr | input | 1 | Table write strobe (to latches) |
| tbl_high | input | 1 | 1 selects the high (23:16) path |
| tbl_byte | input | 1 | 1 selects byte mode |
| tbl_wdata | input | 16 | Write data |
| rd_data | output | 16 | Read result |
| rd_valid | output | 1 | Read result valid |
| cmd_go | input | 1 | Command strobe, target taken from tbl_page/tbl_ea |
| cmd_op | input | 2 | 00 program row, 01/10/11 erase 32/64/128 |
| busy | output | 1 | Command in progress |
| done | output | 1 | Last busy cycle of a command |

## Verification
The bench exercises lane selection with writes through every combination of path and mode: low word, high word, even and odd low bytes, and even and odd high bytes. It reads each result back through every path. This separates swapped lanes, lost zero-extension, and a phantom byte that is wrongly written. The bench also programs the same word twice, with a word left untouched next to it. This shows that programming ANDs into the array and that the latches are cleared. Erases of each size are aimed at unaligned targets in both spaces, followed by reads just inside and just outside each block. Page values that alias to the same word, and writes and commands issued mid-operation, check address wrapping and that input is ignored while busy.

// File: rtl/flash_tbl_pkg.sv
package flash_tbl_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_WORK,
        S_SETTLE,
        S_FINISH
    } fstate_t;

    localparam logic [1:0] OP_PROG      = 2'b00;
    localparam logic [1:0] OP_ERASE_X1  = 2'b01;
    localparam logic [1:0] OP_ERASE_X2  = 2'b10;
    localparam logic [1:0] OP_ERASE_X4  = 2'b11;

    // log2 of the block size in rows for a command
    function automatic logic [1:0] op_scale(input logic [1:0] op);
        unique case (op)
            OP_ERASE_X4: return 2'd2;
            OP_ERASE_X2: return 2'd1;
            default:     return 2'd0;
        endcase
    endfunction
endpackage

// File: rtl/flash_tbl_addr.sv
module flash_tbl_addr #(
    parameter int USER_WORDS = 512,
    parameter int CFG_WORDS  = 128,
    parameter int ROW_WORDS  = 32,
    localparam int IDXW = $clog2(USER_WORDS + CFG_WORDS),
    localparam int SW   = $clog2(ROW_WORDS)
) (
    input  logic [7:0]      page,
    input  logic [15:0]     ea,
    output logic [IDXW-1:0] idx,
    output logic [SW-1:0]   slot,
    output logic            odd,
    output logic            cfg
);
    logic [21:0] offset;

    always_comb begin
        offset = {page[6:0], ea[15:1]};
        cfg    = page[7];
        odd    = ea[0];
        slot   = SW'(offset % ROW_WORDS);
        if (cfg)
            idx = IDXW'(USER_WORDS) + IDXW'(offset % CFG_WORDS);
        else
            idx = IDXW'(offset % USER_WORDS);
    end
endmodule

// File: rtl/flash_tbl_latch.sv
module flash_tbl_latch #(
    parameter int ROW_WORDS = 32,
    localparam int SW = $clog2(ROW_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_slot,
    input  logic          wr_high,
    input  logic          wr_byte,
    input  logic          wr_odd,
    input  logic [15:0]   wr_data,
    input  logic          clr,
    input  logic [SW-1:0] rd_slot,
    output logic [23:0]   rd_word
);
    logic [23:0] lat [ROW_WORDS];

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < ROW_WORDS; i++) lat[i] <= '1;
        end else if (wr_en) begin
            if (!wr_high) begin
                if (!wr_byte)    lat[wr_slot][15:0]  <= wr_data;
                else if (wr_odd) lat[wr_slot][15:8]  <= wr_data[7:0];
                else             lat[wr_slot][7:0]   <= wr_data[7:0];
            end else if (!(wr_byte && wr_odd)) begin
                lat[wr_slot][23:16] <= wr_data[7:0];
            end
        end
    end

    assign rd_word = lat[rd_slot];
endmodule

// File: rtl/flash_tbl_seq.sv
module flash_tbl_seq
    import flash_tbl_pkg::*;
#(
    parameter int ROW_WORDS     = 32,
    parameter int USER_WORDS    = 512,
    parameter int CFG_WORDS     = 128,
    parameter int SETTLE_CYCLES = 6,
    localparam int IDXW = $clog2(USER_WORDS + CFG_WORDS),
    localparam int SW   = $clog2(ROW_WORDS),
    localparam int KW   = $clog2(4 * ROW_WORDS),
    localparam int CW   = $clog2(SETTLE_CYCLES + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic [1:0]      op,
    input  logic [IDXW-1:0] tgt_idx,
    input  logic            tgt_cfg,
    output logic            busy,
    output logic            done,
    output logic            arr_we,
    output logic [IDXW-1:0] arr_idx,
    output logic            arr_prog,
    output logic [SW-1:0]   sweep_slot,
    output logic            latch_clr
);
    fstate_t         st, nx;
    logic [KW-1:0]   k, last_k;
    logic [IDXW-1:0] base;
    logic            prog;
    logic [CW-1:0]   cnt;

    logic [1:0]      scale;
    logic [IDXW-1:0] sbase, local_i, aligned;
    int              shamt;

    always_comb begin
        scale   = op_scale(op);
        shamt   = SW + int'(scale);
        sbase   = tgt_cfg ? IDXW'(USER_WORDS) : '0;
        local_i = tgt_idx - sbase;
        aligned = (local_i >> shamt) << shamt;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nx;
    end

    always_comb begin
        nx = st;
        unique case (st)
            S_IDLE:   if (go) nx = S_WORK;
            S_WORK:   if (k == last_k) nx = S_SETTLE;
            S_SETTLE: if (cnt == '0) nx = S_FINISH;
            S_FINISH: nx = S_IDLE;
        endcase
    end

    // sweep and settle counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            k      <= '0;
            last_k <= '0;
            base   <= '0;
            prog   <= 1'b0;
            cnt    <= '0;
        end else begin
            unique case (st)
                S_IDLE: if (go) begin
                    k      <= '0;
                    last_k <= KW'((ROW_WORDS << scale) - 1);
                    base   <= sbase + aligned;
                    prog   <= (op == OP_PROG);
                end
                S_WORK: begin
                    if (k == last_k) cnt <= CW'(SETTLE_CYCLES - 1);
                    else             k   <= k + 1'b1;
                end
                S_SETTLE: if (cnt != '0) cnt <= cnt - 1'b1;
                S_FINISH: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy       = (st != S_IDLE);
        done       = (st == S_FINISH);
        arr_we     = (st == S_WORK);
        arr_idx    = base + IDXW'(k);
        arr_prog   = prog;
        sweep_slot = k[SW-1:0];
        latch_clr  = (st == S_FINISH) && prog;
    end
endmodule

// File: rtl/flash_tbl_ctrl.sv
module flash_tbl_ctrl #(
    parameter int USER_WORDS    = 512,
    parameter int CFG_WORDS     = 128,
    parameter int ROW_WORDS     = 32,
    parameter int SETTLE_CYCLES = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  tbl_page,
    input  logic [15:0] tbl_ea,
    input  logic        tbl_rd,
    input  logic        tbl_wr,
    input  logic        tbl_high,
    input  logic        tbl_byte,
    input  logic [15:0] tbl_wdata,
    output logic [15:0] rd_data,
    output logic        rd_valid,
    input  logic        cmd_go,
    input  logic [1:0]  cmd_op,
    output logic        busy,
    output logic        done
);
    localparam int TOTAL = USER_WORDS + CFG_WORDS;
    localparam int IDXW  = $clog2(TOTAL);
    localparam int SW    = $clog2(ROW_WORDS);

    logic [IDXW-1:0] a_idx, arr_idx;
    logic [SW-1:0]   a_slot, sweep_slot;
    logic            a_odd, a_cfg;
    logic            arr_we, arr_prog, latch_clr;
    logic [23:0]     lat_word, cur_word;
    logic [15:0]     fmt;
    logic [23:0]     mem [TOTAL];

    flash_tbl_addr #(.USER_WORDS(USER_WORDS), .CFG_WORDS(CFG_WORDS), .ROW_WORDS(ROW_WORDS)) u_addr (
        .page(tbl_page), .ea(tbl_ea), .idx(a_idx), .slot(a_slot), .odd(a_odd), .cfg(a_cfg)
    );

    flash_tbl_latch #(.ROW_WORDS(ROW_WORDS)) u_latch (
        .clk(clk), .rst_n(rst_n), .wr_en(tbl_wr && !busy), .wr_slot(a_slot),
        .wr_high(tbl_high), .wr_byte(tbl_byte), .wr_odd(a_odd), .wr_data(tbl_wdata),
        .clr(latch_clr), .rd_slot(sweep_slot), .rd_word(lat_word)
    );

    flash_tbl_seq #(.ROW_WORDS(ROW_WORDS), .USER_WORDS(USER_WORDS), .CFG_WORDS(CFG_WORDS),
                    .SETTLE_CYCLES(SETTLE_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(cmd_go), .op(cmd_op), .tgt_idx(a_idx), .tgt_cfg(a_cfg),
        .busy(busy), .done(done), .arr_we(arr_we), .arr_idx(arr_idx), .arr_prog(arr_prog),
        .sweep_slot(sweep_slot), .latch_clr(latch_clr)
    );

    // array: program clears bits, erase sets all
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TOTAL; i++) mem[i] <= '1;
        end else if (arr_we) begin
            mem[arr_idx] <= arr_prog ? (mem[arr_idx] & lat_word) : '1;
        end
    end

    // read lane formatting
    always_comb begin
        cur_word = mem[a_idx];
        if (!tbl_high) begin
            if (!tbl_byte)  fmt = cur_word[15:0];
            else if (a_odd) fmt = {8'h00, cur_word[15:8]};
            else            fmt = {8'h00, cur_word[7:0]};
        end else begin
            fmt = (tbl_byte && a_odd) ? 16'h0000 : {8'h00, cur_word[23:16]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= tbl_rd;
            if (tbl_rd) rd_data <= fmt;
        end
    end
endmodule

// File: rtl/flash_tbl_ctrl_chk.sv
module flash_tbl_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] tbl_ea,
    input logic        tbl_rd,
    input logic        tbl_high,
    input logic        tbl_byte,
    input logic [15:0] rd_data,
    input logic        rd_valid,
    input logic        cmd_go,
    input logic        busy,
    input logic        done
);
    p_done_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_ends_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_go) |=> busy);
    p_hold_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    p_rd_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_rd |=> rd_valid);
    p_rd_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !tbl_rd |=> !rd_valid);
    p_high_zext_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_rd && tbl_high) |=> (rd_data[15:8] == 8'h00));
    p_phantom_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_rd && tbl_high && tbl_byte && tbl_ea[0]) |=> (rd_data == 16'h0000));
endmodule

bind flash_tbl_ctrl flash_tbl_ctrl_chk u_chk (.*);

// File: tb/flash_tbl_ctrl_tb.sv
module flash_tbl_ctrl_tb;
    localparam int USERW = 512;
    localparam int CFGW  = 128;
    localparam int ROWW  = 32;
    localparam int SETTLE = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  tbl_page = '0;
    logic [15:0] tbl_ea = '0;
    logic        tbl_rd = 1'b0, tbl_wr = 1'b0, tbl_high = 1'b0, tbl_byte = 1'b0;
    logic [15:0] tbl_wdata = '0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        cmd_go = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic        busy, done;

    always #4 clk = ~clk;

    flash_tbl_ctrl #(.USER_WORDS(USERW), .CFG_WORDS(CFGW), .ROW_WORDS(ROWW), .SETTLE_CYCLES(SETTLE)) u_dut (
        .clk(clk), .rst_n(rst_n), .tbl_page(tbl_page), .tbl_ea(tbl_ea), .tbl_rd(tbl_rd),
        .tbl_wr(tbl_wr), .tbl_high(tbl_high), .tbl_byte(tbl_byte), .tbl_wdata(tbl_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid), .cmd_go(cmd_go), .cmd_op(cmd_op),
        .busy(busy), .done(done)
    );

    int compared = 0, mismatched = 0;
    bit finished = 0;
    string cur_req = "R6";

    // reference model state
    logic [23:0] m_mem [USERW+CFGW];
    logic [23:0] m_lat [ROWW];
    int          busy_left = 0;
    logic        exp_valid = 0;
    logic [15:0] exp_rd = '0;

    function automatic int word_of(input logic [7:0] pg, input logic [15:0] ea);
        int off;
        off = int'({pg[6:0], ea[15:1]});
        return pg[7] ? USERW + (off % CFGW) : (off % USERW);
    endfunction

    function automatic logic [15:0] view(input logic [23:0] w, input logic hi, input logic by, input logic od);
        if (!hi) return by ? (od ? {8'h00, w[15:8]} : {8'h00, w[7:0]}) : w[15:0];
        return (by && od) ? 16'h0000 : {8'h00, w[23:16]};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = '1;
            foreach (m_lat[i]) m_lat[i] = '1;
            busy_left = 0;
            exp_valid <= 1'b0;
        end else begin
            int w, s, len, sb, lb;
            bit was_busy;
            w = word_of(tbl_page, tbl_ea);
            exp_valid <= tbl_rd;
            if (tbl_rd) exp_rd <= view(m_mem[w], tbl_high, tbl_byte, tbl_ea[0]);
            was_busy = (busy_left > 0);
            if (!was_busy && tbl_wr) begin
                s = w % ROWW;
                if (!tbl_high) begin
                    if (!tbl_byte)     m_lat[s][15:0] = tbl_wdata;
                    else if (tbl_ea[0]) m_lat[s][15:8] = tbl_wdata[7:0];
                    else               m_lat[s][7:0]  = tbl_wdata[7:0];
                end else if (!(tbl_byte && tbl_ea[0])) m_lat[s][23:16] = tbl_wdata[7:0];
            end
            if (!was_busy && cmd_go) begin
                len = (cmd_op == 2'b11) ? 4*ROWW : (cmd_op == 2'b10) ? 2*ROWW : ROWW;
                sb = tbl_page[7] ? USERW : 0;
                lb = ((w - sb) / len) * len;
                for (int k = 0; k < len; k++)
                    m_mem[sb+lb+k] = (cmd_op == 2'b00) ? (m_mem[sb+lb+k] & m_lat[k]) : 24'hFFFFFF;
                if (cmd_op == 2'b00) foreach (m_lat[i]) m_lat[i] = '1;
                busy_left = len + SETTLE + 1;
            end else if (was_busy) begin
                busy_left = busy_left - 1;
            end
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R9 busy", 16'(busy), 16'(busy_left > 0));
            chk("R9 done", 16'(done), 16'(busy_left == 1));
            chk("R11 rd_valid", 16'(rd_valid), 16'(exp_valid));
            if (exp_valid && rd_valid) chk(cur_req, rd_data, exp_rd);
        end
    end

    task automatic idle_inputs();
        tbl_rd = 0; tbl_wr = 0; cmd_go = 0;
    endtask

    task automatic twr(input logic [7:0] pg, input int word, input logic od, input logic hi, input logic by, input logic [15:0] d);
        tbl_page = pg; tbl_ea = 16'((word << 1) | int'(od)); tbl_high = hi; tbl_byte = by;
        tbl_wdata = d; tbl_wr = 1;
        @(negedge clk); idle_inputs();
    endtask

    task automatic trd(input logic [7:0] pg, input int word, input logic od, input logic hi, input logic by);
        tbl_page = pg; tbl_ea = 16'((word << 1) | int'(od)); tbl_high = hi; tbl_byte = by; tbl_rd = 1;
        @(negedge clk); idle_inputs();
    endtask

    task automatic read_range(input logic [7:0] pg, input int lo, input int hi_w);
        for (int w = lo; w <= hi_w; w++) begin
            trd(pg, w, 0, 0, 0);
            trd(pg, w, 0, 1, 0);
        end
        @(negedge clk);
    endtask

    task automatic command(input logic [7:0] pg, input int word, input logic [1:0] op);
        tbl_page = pg; tbl_ea = 16'(word << 1); cmd_op = op; cmd_go = 1;
        @(negedge clk); idle_inputs();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R6";
        chk("R6 busy reset", 16'(busy), 16'h0);
        chk("R6 done reset", 16'(done), 16'h0);
        chk("R6 rd_valid reset", 16'(rd_valid), 16'h0);
        rst_n = 1;
        @(negedge clk);
        read_range(8'h00, 0, 3);
        read_range(8'h80, 0, 1);

        cur_req = "R2";
        for (int i = 0; i < 8; i++) twr(8'h00, 32 + i, 0, 0, 0, 16'h1234 + 16'(i * 16'h0101));
        command(8'h00, 32, 2'b00);
        read_range(8'h00, 30, 42);

        cur_req = "R3";
        for (int i = 0; i < 4; i++) twr(8'h00, 64 + i, 0, 1, 0, 16'hFFA5 - 16'(i));
        command(8'h00, 69, 2'b00);
        read_range(8'h00, 63, 68);

        cur_req = "R4";
        twr(8'h00, 96, 0, 0, 1, 16'hEE3C);
        twr(8'h00, 96, 1, 0, 1, 16'h11C3);
        twr(8'h00, 97, 0, 0, 1, 16'h005A);
        command(8'h00, 96, 2'b00);
        for (int w = 96; w <= 97; w++) begin
            trd(8'h00, w, 0, 0, 1);
            trd(8'h00, w, 1, 0, 1);
        end
        read_range(8'h00, 96, 97);

        cur_req = "R5";
        twr(8'h00, 100, 1, 1, 1, 16'h0000);
        twr(8'h00, 101, 0, 1, 1, 16'h0042);
        command(8'h00, 100, 2'b00);
        trd(8'h00, 100, 1, 1, 1);
        trd(8'h00, 101, 1, 1, 1);
        trd(8'h00, 101, 0, 1, 1);
        read_range(8'h00, 100, 101);

        cur_req = "R7";
        twr(8'h00, 32, 0, 0, 0, 16'hF0F0);
        twr(8'h00, 33, 0, 1, 0, 16'h000F);
        command(8'h00, 40, 2'b00);
        read_range(8'h00, 31, 40);

        cur_req = "R1";
        twr(8'h80, 5, 0, 0, 0, 16'hBEEF);
        twr(8'h80, 5, 0, 1, 0, 16'h0077);
        command(8'h80, 5, 2'b00);
        read_range(8'h80, 4, 6);
        read_range(8'h00, 5, 5);
        read_range(8'h81, 5, 5);
        read_range(8'h01, 32, 33);
        read_range(8'h82, 133, 133);

        cur_req = "R8";
        command(8'h00, 45, 2'b01);
        read_range(8'h00, 31, 33);
        read_range(8'h00, 63, 64);
        command(8'h00, 70, 2'b10);
        read_range(8'h00, 63, 64);
        read_range(8'h00, 96, 101);
        read_range(8'h00, 127, 128);
        twr(8'h00, 200, 0, 0, 0, 16'h0000);
        command(8'h00, 200, 2'b00);
        command(8'h80, 77, 2'b11);
        read_range(8'h80, 4, 6);
        read_range(8'h00, 199, 200);
        command(8'h00, 130, 2'b11);
        read_range(8'h00, 127, 128);
        read_range(8'h00, 200, 200);
        read_range(8'h00, 255, 256);

        cur_req = "R10";
        twr(8'h00, 300, 0, 0, 0, 16'h00FF);
        tbl_page = 8'h00; tbl_ea = 16'(300 << 1); cmd_op = 2'b00; cmd_go = 1;
        @(negedge clk); idle_inputs();
        repeat (5) @(negedge clk);
        twr(8'h00, 301, 0, 0, 0, 16'h0000);
        tbl_page = 8'h00; tbl_ea = 16'(301 << 1); cmd_op = 2'b11; cmd_go = 1;
        @(negedge clk); idle_inputs();
        while (busy) @(negedge clk);
        @(negedge clk);
        command(8'h00, 301, 2'b00);
        read_range(8'h00, 299, 302);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule